// File: doc/BRIEF.md
# Dual-Mode Serial Controller Status Flag Register

This block holds the 32-bit status flag word of a serial controller that works either as a plain asynchronous serial port (SCI-compatible mode) or as a node on a LIN bus. The protocol engine outside the block reports each condition with a one-cycle event pulse on the bit position of that flag. The flag stays set until something clears it. Clear sources are a software write of one to the flag, a system reset, a software or module reset request, reception of a new LIN break (bit error and physical bus error only), or software reading the interrupt vector whose code names the flag.

Software write access depends on the mode. LIN-specific flags accept write-one-to-clear only while the controller is in LIN mode. Serial-port-specific flags accept it only in SCI-compatible mode. Plain receive/transmit flags accept it in either mode. Reserved positions always read as zero. The word is read over a simple valid/write-enable register bus at a single word address, and the read data is registered.

Top module: `sci_lin_flag_reg`

## Requirements
- R1: After a system reset (`rst` high), `flags_o` reads 0x0000_0480: transmit-empty (bit 10) and transmit-ready (bit 7) are 1 and every other bit is 0. `bus_rdata_o` is 0.
- R2: An event pulse on `evt_set_i[i]` sets flag i at the next clock edge, for every implemented position: 31..24, 13..5 and 3..0. Positions 23..16, 15, 14 and 4 read 0 whatever the events and writes.
- R3: Write-one-to-clear of the LIN-only flags (bits 31..27, 13, 12, 6, 5, 3, 1; mask 0xF800_306A) takes effect only when `lin_mode_i` is 1.
- R4: Write-one-to-clear of the SCI-only flags (bits 11, 9, 0; mask 0x0000_0A01) takes effect only when `lin_mode_i` is 0.
- R5: Flags 26, 25, 24, 10, 8, 7 and 2 (mask 0x0700_0584) clear on a write of one in either mode. Writing 0 changes nothing, and a write to any address other than `REG_ADDR` changes nothing.
- R6: A pulse on `brk_rx_i` clears bit error (31) and physical bus error (30) and no other flag.
- R7: A pulse on `vec_rd_i` clears flag number `vec_code_i` (code value equals bit index) when that bit is one of 31..24, 13, 12, 11, 9, 8, 6, 5, 3 or 0 (mask 0xFF00_3B69). Any other code clears nothing.
- R8: When a set event and any clear source (write, break, vector read) hit the same flag in the same cycle, the flag ends up set.
- R9: A pulse on `soft_rst_i` or `mod_rst_i` returns all flags to 0x0000_0480 at the next edge, even with set events in the same cycle.
- R10: A read (`bus_vld_i`=1, `bus_we_i`=0, address `REG_ADDR`) returns on `bus_rdata_o` one cycle later the flag word as it was in the read cycle. In any cycle that follows a non-read, `bus_rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| soft_rst_i | input | 1 | Software reset request, returns flags to reset values |
| mod_rst_i | input | 1 | Module reset request, returns flags to reset values |
| lin_mode_i | input | 1 | 1 = LIN mode, 0 = SCI-compatible mode |
| bus_vld_i | input | 1 | Register bus access valid |
| bus_we_i | input | 1 | Register bus write enable |
| bus_addr_i | input | ADDR_W | Register bus word address |
| bus_wdata_i | input | 32 | Write data, a 1 requests clearing that flag |
| bus_rdata_o | output | 32 | Registered read data |
| evt_set_i | input | 32 | One-cycle set events, one per flag position |
| brk_rx_i | input | 1 | New LIN break received |
| vec_rd_i | input | 1 | Interrupt vector read strobe |
| vec_code_i | input | 5 | Vector code read, equal to the flag index |
| flags_o | output | 32 | Current flag word |

## Verification
Every cycle, the assertions check these properties:
- A set event survives any clear in the same cycle.
- Soft and module resets land on the reset word.
- A break leaves bits 31 and 30 clear unless they are being set.
- A vector read clears its mapped flag.
- LIN-only flags hold their value in SCI-compatible mode, and SCI-only flags hold theirs in LIN mode, when no event, break or vector read touches them.
- Read data matches the flag word of the previous cycle or is zero.

The exact mapping of each flag to its access class is shown only by the bench's scenarios. These include mode-swapped write sequences, writes of zero, writes to a wrong address, vector codes outside the mask, and the break affecting nothing but the two error flags.

// File: rtl/sci_lin_flag_pkg.sv
package sci_lin_flag_pkg;
  localparam int unsigned FLAG_W = 32;
  localparam int unsigned CODE_W = $clog2(FLAG_W);

  typedef logic [FLAG_W-1:0] flag_vec_t;

  // positions that hold a flag at all
  localparam flag_vec_t IMPL_MASK    = 32'hFF00_3FEF;
  // value loaded by any reset source
  localparam flag_vec_t RST_VAL      = 32'h0000_0480;
  // software write-one-to-clear classes
  localparam flag_vec_t WR_LIN_MASK  = 32'hF800_306A;
  localparam flag_vec_t WR_SCI_MASK  = 32'h0000_0A01;
  localparam flag_vec_t WR_ANY_MASK  = 32'h0700_0584;
  // flags cleared by a new LIN break
  localparam flag_vec_t BRK_CLR_MASK = 32'hC000_0000;
  // flags that an interrupt vector read can clear
  localparam flag_vec_t VEC_CLR_MASK = 32'hFF00_3B69;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LIN  = 2'd1,
    ACC_SCI  = 2'd2,
    ACC_ANY  = 2'd3
  } acc_class_t;

  function automatic acc_class_t acc_class(input int unsigned idx);
    if (WR_LIN_MASK[idx])      return ACC_LIN;
    else if (WR_SCI_MASK[idx]) return ACC_SCI;
    else if (WR_ANY_MASK[idx]) return ACC_ANY;
    else                       return ACC_NONE;
  endfunction
endpackage

// File: rtl/sci_lin_flag_cell.sv
module sci_lin_flag_cell #(
  parameter logic RST_BIT = 1'b0
) (
  input  logic clk,
  input  logic clr_all_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // reset request beats set, set beats every ordinary clear
  always_ff @(posedge clk) begin
    if (clr_all_i)  q_o <= RST_BIT;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/sci_lin_flag_wr_dec.sv
module sci_lin_flag_wr_dec
  import sci_lin_flag_pkg::*;
#(
  parameter int unsigned           ADDR_W   = 8,
  parameter logic [ADDR_W-1:0]     REG_ADDR = '0
) (
  input  logic              bus_vld_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  flag_vec_t         bus_wdata_i,
  input  logic              lin_mode_i,
  output flag_vec_t         sw_clr_o
);
  flag_vec_t allow;
  logic      hit;

  // per-bit write permission from its access class and the active mode
  for (genvar i = 0; i < FLAG_W; i++) begin : g_allow
    localparam acc_class_t CLS = acc_class(i);
    if (CLS == ACC_LIN) begin : g_lin
      assign allow[i] = lin_mode_i;
    end else if (CLS == ACC_SCI) begin : g_sci
      assign allow[i] = ~lin_mode_i;
    end else if (CLS == ACC_ANY) begin : g_any
      assign allow[i] = 1'b1;
    end else begin : g_none
      assign allow[i] = 1'b0;
    end
  end

  always_comb begin
    hit      = bus_vld_i && bus_we_i && (bus_addr_i == REG_ADDR);
    sw_clr_o = hit ? (bus_wdata_i & allow) : '0;
  end
endmodule

// File: rtl/sci_lin_flag_vec_dec.sv
module sci_lin_flag_vec_dec
  import sci_lin_flag_pkg::*;
(
  input  logic              vec_rd_i,
  input  logic [CODE_W-1:0] vec_code_i,
  output flag_vec_t         vec_clr_o
);
  for (genvar i = 0; i < FLAG_W; i++) begin : g_code
    if (VEC_CLR_MASK[i]) begin : g_map
      assign vec_clr_o[i] = vec_rd_i && (vec_code_i == CODE_W'(i));
    end else begin : g_nomap
      assign vec_clr_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/sci_lin_flag_rd_port.sv
module sci_lin_flag_rd_port
  import sci_lin_flag_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_vld_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  flag_vec_t         flags_i,
  output flag_vec_t         bus_rdata_o
);
  logic rd_hit;

  assign rd_hit = bus_vld_i && !bus_we_i && (bus_addr_i == REG_ADDR);

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata_o <= '0;
    else if (rd_hit) bus_rdata_o <= flags_i;
    else             bus_rdata_o <= '0;
  end
endmodule

// File: rtl/sci_lin_flag_reg.sv
module sci_lin_flag_reg
  import sci_lin_flag_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst_i,
  input  logic              mod_rst_i,
  input  logic              lin_mode_i,
  input  logic              bus_vld_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [31:0]       evt_set_i,
  input  logic              brk_rx_i,
  input  logic              vec_rd_i,
  input  logic [4:0]        vec_code_i,
  output logic [31:0]       flags_o
);
  flag_vec_t sw_clr;
  flag_vec_t vec_clr;
  flag_vec_t brk_clr;
  flag_vec_t any_clr;
  logic      clr_all;
  logic      unused_bits;

  assign clr_all = rst | soft_rst_i | mod_rst_i;
  assign brk_clr = brk_rx_i ? BRK_CLR_MASK : '0;
  assign any_clr = sw_clr | vec_clr | brk_clr;

  sci_lin_flag_wr_dec #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR)
  ) u_wr_dec (
    .bus_vld_i   (bus_vld_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .lin_mode_i  (lin_mode_i),
    .sw_clr_o    (sw_clr)
  );

  sci_lin_flag_vec_dec u_vec_dec (
    .vec_rd_i   (vec_rd_i),
    .vec_code_i (vec_code_i),
    .vec_clr_o  (vec_clr)
  );

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    if (IMPL_MASK[i]) begin : g_cell
      sci_lin_flag_cell #(
        .RST_BIT (RST_VAL[i])
      ) u_cell (
        .clk       (clk),
        .clr_all_i (clr_all),
        .set_i     (evt_set_i[i]),
        .clr_i     (any_clr[i]),
        .q_o       (flags_o[i])
      );
    end else begin : g_rsvd
      assign flags_o[i] = 1'b0;
    end
  end

  assign unused_bits = ^{evt_set_i & ~IMPL_MASK, any_clr & ~IMPL_MASK};

  sci_lin_flag_rd_port #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR)
  ) u_rd_port (
    .clk         (clk),
    .rst         (rst),
    .bus_vld_i   (bus_vld_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .flags_i     (flags_o),
    .bus_rdata_o (bus_rdata_o)
  );
endmodule

// File: rtl/sci_lin_flag_chk.sv
module sci_lin_flag_chk
  import sci_lin_flag_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              soft_rst_i,
  input logic              mod_rst_i,
  input logic              lin_mode_i,
  input logic              bus_vld_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_rdata_o,
  input logic [31:0]       evt_set_i,
  input logic              brk_rx_i,
  input logic              vec_rd_i,
  input logic [4:0]        vec_code_i,
  input logic [31:0]       flags_o
);
  logic quiet_rst;
  logic rd_req;

  assign quiet_rst = !soft_rst_i && !mod_rst_i;
  assign rd_req    = bus_vld_i && !bus_we_i && (bus_addr_i == REG_ADDR);

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (quiet_rst && ((evt_set_i & IMPL_MASK) != '0))
    |=> ((flags_o & $past(evt_set_i & IMPL_MASK)) == $past(evt_set_i & IMPL_MASK))); // R8

  AST_SOFT_RST_VAL: assert property (@(posedge clk) disable iff (rst)
    (soft_rst_i || mod_rst_i) |=> (flags_o == RST_VAL)); // R9

  AST_BRK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (brk_rx_i && quiet_rst && ((evt_set_i & BRK_CLR_MASK) == '0))
    |=> ((flags_o & BRK_CLR_MASK) == '0)); // R6

  AST_VEC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (vec_rd_i && VEC_CLR_MASK[vec_code_i] && !evt_set_i[vec_code_i] && quiet_rst)
    |=> !flags_o[$past(vec_code_i)]); // R7

  AST_LIN_HOLD_IN_SCI: assert property (@(posedge clk) disable iff (rst)
    (!lin_mode_i && quiet_rst && !brk_rx_i && !vec_rd_i
     && ((evt_set_i & WR_LIN_MASK) == '0))
    |=> ((flags_o & WR_LIN_MASK) == $past(flags_o & WR_LIN_MASK))); // R3

  AST_SCI_HOLD_IN_LIN: assert property (@(posedge clk) disable iff (rst)
    (lin_mode_i && quiet_rst && !vec_rd_i
     && ((evt_set_i & WR_SCI_MASK) == '0))
    |=> ((flags_o & WR_SCI_MASK) == $past(flags_o & WR_SCI_MASK))); // R4

  AST_RDATA_MATCH: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> (bus_rdata_o == $past(flags_o))); // R10

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> (bus_rdata_o == '0)); // R10
endmodule

bind sci_lin_flag_reg sci_lin_flag_chk #(
  .ADDR_W   (ADDR_W),
  .REG_ADDR (REG_ADDR)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .soft_rst_i  (soft_rst_i),
  .mod_rst_i   (mod_rst_i),
  .lin_mode_i  (lin_mode_i),
  .bus_vld_i   (bus_vld_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o),
  .evt_set_i   (evt_set_i),
  .brk_rx_i    (brk_rx_i),
  .vec_rd_i    (vec_rd_i),
  .vec_code_i  (vec_code_i),
  .flags_o     (flags_o)
);

// File: tb/test_sci_lin_flag_reg.sv
`timescale 1ns/1ps
module test_sci_lin_flag_reg;
  localparam int unsigned ADDR_W   = 8;
  localparam logic [7:0]  REG_ADDR = 8'h24;
  localparam logic [31:0] RST_WORD = 32'h0000_0480;

  typedef struct packed {
    logic        lin;
    logic [31:0] set;
    logic        wr;
    logic [31:0] wd;
    logic        brk;
    logic        vrd;
    logic [4:0]  code;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0,         1'b0, 1'b0, 5'd0,  32'hFF00_3FEF, 4'd2}, // R2 all set
    '{1'b0, 32'h0,         1'b1, 32'hF800_306A, 1'b0, 1'b0, 5'd0,  32'hFF00_3FEF, 4'd3}, // R3 blocked in SCI
    '{1'b1, 32'h0,         1'b1, 32'hF800_306A, 1'b0, 1'b0, 5'd0,  32'h0700_0F85, 4'd3}, // R3 clears in LIN
    '{1'b1, 32'h0,         1'b1, 32'h0000_0A01, 1'b0, 1'b0, 5'd0,  32'h0700_0F85, 4'd4}, // R4 blocked in LIN
    '{1'b0, 32'h0,         1'b1, 32'h0000_0A01, 1'b0, 1'b0, 5'd0,  32'h0700_0584, 4'd4}, // R4 clears in SCI
    '{1'b0, 32'h0,         1'b1, 32'h0,         1'b0, 1'b0, 5'd0,  32'h0700_0584, 4'd5}, // R5 zero write
    '{1'b1, 32'h0,         1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 5'd0,  32'h0000_0000, 4'd5}, // R5 any-mode clear
    '{1'b0, 32'hC000_0000, 1'b0, 32'h0,         1'b1, 1'b0, 5'd0,  32'hC000_0000, 4'd8}, // R8 set beats break
    '{1'b0, 32'h2000_0000, 1'b0, 32'h0,         1'b1, 1'b0, 5'd0,  32'h2000_0000, 4'd6}, // R6 break clears 31,30
    '{1'b0, 32'h0,         1'b0, 32'h0,         1'b1, 1'b0, 5'd0,  32'h2000_0000, 4'd6}, // R6 bit 29 kept
    '{1'b0, 32'h0000_3B69, 1'b0, 32'h0,         1'b0, 1'b0, 5'd0,  32'h2000_3B69, 4'd2}, // R2 low flags
    '{1'b0, 32'h0,         1'b0, 32'h0,         1'b0, 1'b1, 5'd29, 32'h0000_3B69, 4'd7}, // R7 code 29
    '{1'b0, 32'h0,         1'b0, 32'h0,         1'b0, 1'b1, 5'd13, 32'h0000_1B69, 4'd7}, // R7 code 13
    '{1'b0, 32'h0000_0004, 1'b0, 32'h0,         1'b0, 1'b0, 5'd0,  32'h0000_1B6D, 4'd2}, // R2 busy
    '{1'b0, 32'h0,         1'b0, 32'h0,         1'b0, 1'b1, 5'd2,  32'h0000_1B6D, 4'd7}, // R7 unmapped code
    '{1'b0, 32'h0,         1'b0, 32'h0,         1'b0, 1'b1, 5'd0,  32'h0000_1B6C, 4'd7}, // R7 code 0
    '{1'b0, 32'h0000_1000, 1'b0, 32'h0,         1'b0, 1'b1, 5'd12, 32'h0000_1B6C, 4'd8}, // R8 set beats vector read
    '{1'b1, 32'h0000_1000, 1'b1, 32'h0000_1000, 1'b0, 1'b0, 5'd0,  32'h0000_1B6C, 4'd8}  // R8 set beats write
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              soft_rst_i = 1'b0;
  logic              mod_rst_i = 1'b0;
  logic              lin_mode_i = 1'b0;
  logic              bus_vld_i = 1'b0;
  logic              bus_we_i = 1'b0;
  logic [ADDR_W-1:0] bus_addr_i = '0;
  logic [31:0]       bus_wdata_i = '0;
  logic [31:0]       bus_rdata_o;
  logic [31:0]       evt_set_i = '0;
  logic              brk_rx_i = 1'b0;
  logic              vec_rd_i = 1'b0;
  logic [4:0]        vec_code_i = '0;
  logic [31:0]       flags_o;

  int n_checks = 0;
  int n_fails  = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  sci_lin_flag_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) i_sci_lin_flag_reg (
    .clk(clk), .rst(rst), .soft_rst_i(soft_rst_i), .mod_rst_i(mod_rst_i),
    .lin_mode_i(lin_mode_i), .bus_vld_i(bus_vld_i), .bus_we_i(bus_we_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .evt_set_i(evt_set_i), .brk_rx_i(brk_rx_i), .vec_rd_i(vec_rd_i),
    .vec_code_i(vec_code_i), .flags_o(flags_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    soft_rst_i = 1'b0; mod_rst_i = 1'b0;
    bus_vld_i = 1'b0; bus_we_i = 1'b0; bus_addr_i = REG_ADDR; bus_wdata_i = '0;
    evt_set_i = '0; brk_rx_i = 1'b0; vec_rd_i = 1'b0; vec_code_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset flags", flags_o, RST_WORD);
    check("R1 reset rdata", bus_rdata_o, 32'h0);

    for (int k = 0; k < NV; k++) begin
      lin_mode_i  = VECS[k].lin;
      evt_set_i   = VECS[k].set;
      bus_vld_i   = VECS[k].wr;
      bus_we_i    = VECS[k].wr;
      bus_addr_i  = REG_ADDR;
      bus_wdata_i = VECS[k].wd;
      brk_rx_i    = VECS[k].brk;
      vec_rd_i    = VECS[k].vrd;
      vec_code_i  = VECS[k].code;
      @(negedge clk);
      check($sformatf("R%0d row %0d", VECS[k].req, k), flags_o, VECS[k].exp);
      idle_inputs();
    end

    // R10 read returns word of read cycle, then zero
    bus_vld_i = 1'b1; bus_we_i = 1'b0;
    @(negedge clk);
    check("R10 read data", bus_rdata_o, 32'h0000_1B6C);
    idle_inputs();
    @(negedge clk);
    check("R10 idle rdata", bus_rdata_o, 32'h0);

    // R5 write to another address ignored
    lin_mode_i = 1'b1;
    bus_vld_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = REG_ADDR + 8'd1; bus_wdata_i = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R5 wrong address", flags_o, 32'h0000_1B6C);
    idle_inputs();

    // R9 soft reset
    soft_rst_i = 1'b1;
    @(negedge clk);
    check("R9 soft reset", flags_o, RST_WORD);
    idle_inputs();
    evt_set_i = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R2 set all again", flags_o, 32'hFF00_3FEF);
    idle_inputs();

    // R9 module reset wins over set
    mod_rst_i = 1'b1; evt_set_i = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R9 module reset over set", flags_o, RST_WORD);
    idle_inputs();

    // R1 system reset mid-run
    evt_set_i = 32'h0100_0000;
    bus_vld_i = 1'b1; bus_we_i = 1'b0;
    @(negedge clk);
    idle_inputs();
    rst = 1'b1;
    @(negedge clk);
    check("R1 hard reset flags", flags_o, RST_WORD);
    check("R1 hard reset rdata", bus_rdata_o, 32'h0);
    rst = 1'b0;
    @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end
endmodule